// File: doc/BRIEF.md
# GPIO Grouped Interrupt Controller

This block gathers interrupt requests from up to four 32-bit GPIO ports into eight shared interrupt groups. Each group has a 4-bit route selector that picks one input pin for that group. The selector chooses the port and the byte lane, and the group number fixes the bit inside that lane. The chosen pin passes through a two-flop synchroniser. A 3-bit trigger mode then turns it into a pending bit: a level condition, an edge condition, a forced request, or nothing.

Software reaches the block over a plain 32-bit register bus: an address, a write strobe, write data and registered read data. Through that bus it writes the trigger modes, the route selectors and the group mask. It clears pending edge requests by writing ones to an acknowledge register, and it reads the masked pending bits back. A single registered interrupt line goes high whenever any masked group is pending.

Top module: `gpio_grp_irq`

## Requirements
- R1: Group g samples pin bit (sel/4)*32 + (sel%4)*8 + g of the concatenated port bus, where sel is the group's route field. No other pin affects the group. The sampled pin passes through two flops before detection, and edge detection compares the synchronised value with its value one cycle earlier.
- R2: The trigger register at byte address 120 holds group g's mode in bits [3g+2:3g]. The route register at address 124 holds group g's selector in bits [4g+3:4g]. Both read back what was written, and trigger bits 31:24 read as zero.
- R3: Mode 1 (high) and mode 2 (low) make the pending bit follow the synchronised pin condition: it is set while the pin is high (mode 1) or low (mode 2) and clear otherwise. An acknowledge does not clear it while the condition holds.
- R4: Mode 3 holds the group's pending bit set whatever the pin does. Modes 0 and 4 keep it clear.
- R5: Modes 5 (rising), 6 (falling) and 7 (either edge) set the pending bit on the selected edge. The bit stays set after the pin settles.
- R6: Writing address 132 with bit g set clears group g's pending edge request. Zero bits have no effect. An edge that arrives in the same cycle as the acknowledge leaves the bit set.
- R7: The mask register at address 128 holds one enable per group in bits [7:0]. The status register at address 140 reads pending AND mask in bits [7:0], with zeros above.
- R8: irq_out is a register holding the OR of the masked pending bits from the previous cycle.
- R9: After reset the trigger, route and mask registers read zero. Reads of the acknowledge address and of unmapped addresses return zero. Writes to the status address have no effect.
- R10: bus_rdata shows the register addressed at a clock edge, with the value held before that edge, from the edge until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| gpio_in | input | 128 | Four 32-bit ports, port p at bits [32p+31:32p] |
| irq_out | output | 1 | Combined registered interrupt request |

## Verification
Directed patterns check each behaviour separately. One pattern drives a level-high pin on a routed lane while an unrouted pin toggles, which shows the route really selects a single pin. A pulse that rises and then falls separates sticky edge capture from level following. An acknowledge timed to land on the same edge as a new transition tests the set-over-clear priority. Forced and disabled modes show that the pin has no effect in them, and masking a pending group shows that the mask gates both status and irq_out without touching the pending bit. A long random phase changes pins, modes, routes, masks and acknowledges every cycle, compared against a behavioural model.

// File: rtl/gpio_grp_pkg.sv
package gpio_grp_pkg;
  localparam int GROUPS = 8;
  localparam int MODE_W = 3;
  localparam int SEL_W  = 4;

  typedef enum logic [2:0] {
    TRIG_OFF   = 3'd0,
    TRIG_HIGH  = 3'd1,
    TRIG_LOW   = 3'd2,
    TRIG_FORCE = 3'd3,
    TRIG_RSVD  = 3'd4,
    TRIG_RISE  = 3'd5,
    TRIG_FALL  = 3'd6,
    TRIG_BOTH  = 3'd7
  } trig_e;

  localparam int ADR_TRIG  = 120;
  localparam int ADR_ROUTE = 124;
  localparam int ADR_MASK  = 128;
  localparam int ADR_ACK   = 132;
  localparam int ADR_STAT  = 140;
endpackage

// File: rtl/gpio_grp_route.sv
module gpio_grp_route #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 32,
  parameter int GROUP     = 0,
  parameter int SEL_W     = 4
) (
  input  logic [NUM_PORTS*PORT_W-1:0] gpio,
  input  logic [SEL_W-1:0]            sel,
  output logic                        pin
);
  localparam int LANES = PORT_W / 8;

  always_comb begin
    pin = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      for (int l = 0; l < LANES; l++) begin
        if (sel == SEL_W'(p * LANES + l))
          pin = gpio[p*PORT_W + l*8 + GROUP];
      end
    end
  end
endmodule

// File: rtl/gpio_grp_detect.sv
module gpio_grp_detect
  import gpio_grp_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pin_raw,
  input  trig_e mode,
  input  logic  ack,
  output logic  pend
);
  logic sync_a, sync_b, prev;
  logic rise, fall, pend_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      prev   <= 1'b0;
    end else begin
      sync_a <= pin_raw;
      sync_b <= sync_a;
      prev   <= sync_b;
    end
  end

  assign rise = sync_b & ~prev;
  assign fall = ~sync_b & prev;

  always_comb begin
    unique case (mode)
      TRIG_HIGH:  pend_nx = sync_b;
      TRIG_LOW:   pend_nx = ~sync_b;
      TRIG_FORCE: pend_nx = 1'b1;
      TRIG_RISE:  pend_nx = rise | (pend & ~ack);
      TRIG_FALL:  pend_nx = fall | (pend & ~ack);
      TRIG_BOTH:  pend_nx = rise | fall | (pend & ~ack);
      default:    pend_nx = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= pend_nx;
  end

  // R4: forced mode sets the pending bit on the next edge
  a_r4_force_sets: assert property (@(posedge clk) disable iff (rst)
    (mode == TRIG_FORCE) |=> pend);
  // R4: disabled codes never leave a pending bit
  a_r4_off_clears: assert property (@(posedge clk) disable iff (rst)
    (mode == TRIG_OFF || mode == TRIG_RSVD) |=> !pend);
  // R5: edge request is held without an acknowledge
  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    ((mode == TRIG_RISE || mode == TRIG_FALL || mode == TRIG_BOTH) && pend && !ack) |=> pend);
  // R6: a rising edge wins against a coincident acknowledge
  a_r6_edge_beats_ack: assert property (@(posedge clk) disable iff (rst)
    ((mode == TRIG_RISE) && sync_b && !prev) |=> pend);
endmodule

// File: rtl/gpio_grp_regs.sv
module gpio_grp_regs
  import gpio_grp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NG     = GROUPS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 we,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NG-1:0]        masked,
  output logic [NG*MODE_W-1:0] trig_q,
  output logic [NG*SEL_W-1:0]  route_q,
  output logic [NG-1:0]        mask_q,
  output logic [NG-1:0]        ack,
  output logic [DATA_W-1:0]    rdata
);
  logic hit_trig, hit_route, hit_mask, hit_ack, hit_stat;

  assign hit_trig  = (addr == ADDR_W'(ADR_TRIG));
  assign hit_route = (addr == ADDR_W'(ADR_ROUTE));
  assign hit_mask  = (addr == ADDR_W'(ADR_MASK));
  assign hit_ack   = (addr == ADDR_W'(ADR_ACK));
  assign hit_stat  = (addr == ADDR_W'(ADR_STAT));

  assign ack = (we && hit_ack) ? wdata[NG-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q  <= '0;
      route_q <= '0;
      mask_q  <= '0;
    end else if (we) begin
      if (hit_trig)  trig_q  <= wdata[NG*MODE_W-1:0];
      if (hit_route) route_q <= wdata[NG*SEL_W-1:0];
      if (hit_mask)  mask_q  <= wdata[NG-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (hit_trig)  rdata <= DATA_W'(trig_q);
    else if (hit_route) rdata <= DATA_W'(route_q);
    else if (hit_mask)  rdata <= DATA_W'(mask_q);
    else if (hit_stat)  rdata <= DATA_W'(masked);
    else                rdata <= '0;
  end

  // R2: trigger register holds its value without a write to it
  a_r2_trig_hold: assert property (@(posedge clk) disable iff (rst)
    !(we && hit_trig) |=> $stable(trig_q));
  // R9: reads outside the map return zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    !(hit_trig || hit_route || hit_mask || hit_stat) |=> (rdata == '0));
endmodule

// File: rtl/gpio_grp_irq.sv
module gpio_grp_irq
  import gpio_grp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_we,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0] gpio_in,
  output logic                        irq_out
);
  logic [GROUPS*MODE_W-1:0] trig_q;
  logic [GROUPS*SEL_W-1:0]  route_q;
  logic [GROUPS-1:0]        mask_q, ack, pend, masked;

  gpio_grp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NG(GROUPS)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .masked(masked), .trig_q(trig_q), .route_q(route_q), .mask_q(mask_q),
    .ack(ack), .rdata(bus_rdata)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic pin;
    gpio_grp_route #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .GROUP(g), .SEL_W(SEL_W)) u_route (
      .gpio(gpio_in), .sel(route_q[g*SEL_W +: SEL_W]), .pin(pin)
    );
    gpio_grp_detect u_det (
      .clk(clk), .rst(rst), .pin_raw(pin),
      .mode(trig_e'(trig_q[g*MODE_W +: MODE_W])),
      .ack(ack[g]), .pend(pend[g])
    );
  end

  assign masked = pend & mask_q;

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |masked;
  end

  // R8: any masked request raises the line one cycle later
  a_r8_irq_rise: assert property (@(posedge clk) disable iff (rst)
    (|masked) |=> irq_out);
  // R8: no masked request keeps the line low one cycle later
  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    !(|masked) |=> !irq_out);
  // R7: a masked-off group never drives the line alone
  a_r7_mask_gate: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq_out);
endmodule

// File: tb/gpio_grp_irq_bench.sv
module gpio_grp_irq_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [7:0]   bus_addr = '0;
  logic         bus_we = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [127:0] gpio_in = '0;
  logic         irq_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_grp_irq u_gpio_grp_irq (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_in(gpio_in), .irq_out(irq_out)
  );

  // behavioural reference
  bit [31:0] m_trig, m_route, m_rdata;
  bit [7:0]  m_mask, m_pend;
  bit        m_irq;
  bit        m_s1 [8];
  bit        m_s2 [8];
  bit        m_pv [8];

  always @(posedge clk) begin
    if (rst) begin
      m_trig = 0; m_route = 0; m_mask = 0; m_pend = 0; m_irq = 0; m_rdata = 0;
      for (int g = 0; g < 8; g++) begin m_s1[g] = 0; m_s2[g] = 0; m_pv[g] = 0; end
    end else begin
      bit [7:0] np;
      bit [7:0] ackv;
      case (bus_addr)
        8'd120:  m_rdata = m_trig & 32'h00FF_FFFF;
        8'd124:  m_rdata = m_route;
        8'd128:  m_rdata = {24'd0, m_mask};
        8'd140:  m_rdata = {24'd0, m_pend & m_mask};
        default: m_rdata = 0;
      endcase
      m_irq = ((m_pend & m_mask) != 0);
      ackv = (bus_we && bus_addr == 8'd132) ? bus_wdata[7:0] : 8'd0;
      for (int g = 0; g < 8; g++) begin
        int mode;
        bit held, rs, fl;
        mode = (m_trig >> (3*g)) & 7;
        held = m_pend[g] && !ackv[g];
        rs = m_s2[g] && !m_pv[g];
        fl = !m_s2[g] && m_pv[g];
        case (mode)
          1: np[g] = m_s2[g];
          2: np[g] = !m_s2[g];
          3: np[g] = 1;
          5: np[g] = rs || held;
          6: np[g] = fl || held;
          7: np[g] = rs || fl || held;
          default: np[g] = 0;
        endcase
      end
      for (int g = 0; g < 8; g++) begin
        int sel;
        sel = (m_route >> (4*g)) & 15;
        m_pv[g] = m_s2[g];
        m_s2[g] = m_s1[g];
        m_s1[g] = gpio_in[(sel/4)*32 + (sel%4)*8 + g];
      end
      m_pend = np;
      if (bus_we) begin
        if (bus_addr == 8'd120) m_trig = bus_wdata & 32'h00FF_FFFF;
        if (bus_addr == 8'd124) m_route = bus_wdata;
        if (bus_addr == 8'd128) m_mask = bus_wdata[7:0];
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R8 irq_out", {31'd0, irq_out}, {31'd0, m_irq});
      check("R10 bus_rdata", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'd0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
    bus_addr = 8'd0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    rd(8'd120, v); check("R9 trig reset", v, 0);
    rd(8'd124, v); check("R9 route reset", v, 0);
    rd(8'd128, v); check("R9 mask reset", v, 0);
    rd(8'd132, v); check("R9 ack reads zero", v, 0);
    rd(8'd136, v); check("R9 unmapped zero", v, 0);
    check("R8 irq reset", {31'd0, irq_out}, 0);
    // R2 readback
    wr(8'd120, 32'hFF00_0000); wr(8'd124, 32'hFEDC_BA98);
    rd(8'd120, v); check("R2 trig upper bits zero", v, 32'h0);
    rd(8'd124, v); check("R2 route readback", v, 32'hFEDC_BA98);
    wr(8'd124, 0);
    // R1/R3 level high on port 1 lane 2 (sel 6 -> bit 48)
    wr(8'd124, 32'h6); wr(8'd120, 32'h1); wr(8'd128, 32'h1);
    gpio_in[0] = 1'b1; idle(5);
    rd(8'd140, v); check("R1 unrouted pin ignored", v, 0);
    gpio_in[48] = 1'b1; idle(5);
    rd(8'd140, v); check("R1 routed pin level high", v, 32'h1);
    wr(8'd132, 32'h1); idle(1);
    rd(8'd140, v); check("R3 ack ignored while high", v, 32'h1);
    wr(8'd120, 32'h2); idle(3);
    rd(8'd140, v); check("R3 low mode with pin high", v, 0);
    gpio_in[48] = 1'b0; idle(5);
    rd(8'd140, v); check("R3 low mode with pin low", v, 32'h1);
    gpio_in[0] = 1'b0;
    // R4 forced and disabled
    wr(8'd120, 32'h3 << 6); wr(8'd128, 32'h4); idle(3);
    rd(8'd140, v); check("R4 forced pending", v, 32'h4);
    check("R8 irq on forced", {31'd0, irq_out}, 1);
    wr(8'd120, 32'h4 << 6); idle(3);
    rd(8'd140, v); check("R4 code 4 clears", v, 0);
    // R5/R6 rising edge on group 3 (route 0 -> bit 3)
    wr(8'd124, 0); wr(8'd120, 32'h5 << 9); wr(8'd128, 32'h8); idle(3);
    gpio_in[3] = 1'b1; idle(5);
    gpio_in[3] = 1'b0; idle(5);
    rd(8'd140, v); check("R5 rising edge sticky", v, 32'h8);
    wr(8'd132, 32'h0); rd(8'd140, v); check("R6 zero ack no effect", v, 32'h8);
    wr(8'd132, 32'hF7); rd(8'd140, v); check("R6 other bits no effect", v, 32'h8);
    wr(8'd128, 32'h0); rd(8'd140, v); check("R7 masked off status", v, 0);
    check("R7 masked off irq", {31'd0, irq_out}, 0);
    wr(8'd128, 32'h8); rd(8'd140, v); check("R7 pending kept under mask", v, 32'h8);
    wr(8'd132, 32'h8); rd(8'd140, v); check("R6 ack clears edge", v, 0);
    wr(8'd140, 32'hFF); rd(8'd140, v); check("R9 status write ignored", v, 0);
    // R5 falling edge
    wr(8'd120, 32'h6 << 9); gpio_in[3] = 1'b1; idle(5);
    rd(8'd140, v); check("R5 falling ignores rise", v, 0);
    gpio_in[3] = 1'b0; idle(5);
    rd(8'd140, v); check("R5 falling edge captured", v, 32'h8);
    // R6 coincident edge and acknowledge, both edges on group 5
    wr(8'd120, 32'h7 << 15); wr(8'd128, 32'h20); idle(2);
    gpio_in[5] = 1'b1; idle(5);
    @(negedge clk); gpio_in[5] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_addr = 8'd132; bus_we = 1'b1; bus_wdata = 32'h20;
    @(negedge clk); bus_we = 1'b0; bus_addr = 8'd0;
    rd(8'd140, v); check("R6 edge beats ack", v, 32'h20);
    wr(8'd132, 32'h20); rd(8'd140, v); check("R6 later ack clears", v, 0);
    // random phase against the reference
    for (int i = 0; i < 4000; i++) begin
      int op;
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) gpio_in = {$urandom, $urandom, $urandom, $urandom};
      op = $urandom_range(0, 9);
      bus_we = (op < 5);
      bus_wdata = $urandom;
      case (op % 7)
        0: bus_addr = 8'd120;
        1: bus_addr = 8'd124;
        2: bus_addr = 8'd128;
        3: bus_addr = 8'd132;
        4: bus_addr = 8'd140;
        5: bus_addr = 8'd136;
        default: bus_addr = 8'd140;
      endcase
    end
    @(negedge clk); bus_we = 1'b0;
    idle(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired R10");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule